// File: doc/BRIEF.md
# USB Device Transaction Responder

This block sits after a USB packet receiver and decides, for each received packet, whether a simple device endpoint stays silent, replies with a one-byte handshake, or sends the packet held in its transmit buffer. The receiver strobes `pkt_valid` once per packet. With the strobe it presents the packet length, the first byte (the PID) and the second byte. The responder compares token packets against the device address. It holds the PID of the last addressed SETUP or OUT token as pending state and admits a following DATA0 or DATA1 packet into one of two alternating receive buffers.

The application side loads a transmit packet by giving its length with a load strobe. It frees a receive buffer with a consumed strobe. Each decision is registered one clock after the strobe, so a reply request always leaves well inside the turnaround window of about 6.5 bit times. Packets may arrive on consecutive cycles, so a data packet that directly follows its token is handled with no idle gap.

Top module: `usb_txn_responder`

## Requirements
- R1: A packet whose length is below 3 bytes produces no reply and no delivery.
- R2: DATA0 (0xC3) and DATA1 (0x4B) are recognised before any address check, so the second byte of a data packet is never compared with the device address.
- R3: For a token, bits [6:0] of the byte after the PID are compared with `dev_addr` and bit 7 is ignored. On a mismatch the token is dropped with no reply.
- R4: An addressed SETUP (0x2D) or OUT (0xE1) token becomes the pending token and produces no reply.
- R5: Every dropped packet clears the pending token: a short packet, an address mismatch, an unknown PID, or data with no pending token. A data packet with no pending token gets no reply.
- R6: A data packet with a token pending while the receive buffer is still occupied is answered with NAK (0x5A). It is not delivered and the pending token is kept.
- R7: An accepted data packet sets `rx_done_valid` for one cycle with its length, the pending token PID and the buffer index it used, toggles `rx_wr_sel`, and is answered with ACK (0xD2). The buffer stays occupied until `rx_consumed`.
- R8: An addressed IN (0x69) token is answered with NAK when no transmit packet is loaded or when a received packet is still unconsumed.
- R9: Otherwise an IN token requests the transmit buffer (`reply_src` = 2) with its loaded length and `reply_pid` 0, and marks the transmit slot free.
- R10: A reply appears in the cycle after the `pkt_valid` strobe and lasts one cycle. Strobes on consecutive cycles are each handled.
- R11: A handshake reply has `reply_src` = 1 and `reply_len` = 1, and `reply_pid` carries its PID. When there is no reply, `reply_src` is 0.
- R12: After reset there is no reply and no delivery, `rx_wr_sel` is 0, and neither buffer is occupied or loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | One-cycle strobe: a complete packet is presented |
| pkt_len | input | LEN_W | Packet length in bytes |
| pkt_pid | input | 8 | First packet byte (PID) |
| pkt_byte1 | input | 8 | Second packet byte |
| dev_addr | input | 7 | Device address |
| tx_load | input | 1 | Strobe: the transmit buffer now holds a packet |
| tx_load_len | input | LEN_W | Length of the loaded transmit packet |
| rx_consumed | input | 1 | Strobe: the application has taken the received packet |
| reply_valid | output | 1 | Reply request, one cycle |
| reply_src | output | 2 | 0 none, 1 handshake, 2 transmit buffer |
| reply_pid | output | 8 | Handshake PID, 0 for a buffer reply |
| reply_len | output | LEN_W | Bytes to send |
| rx_done_valid | output | 1 | Accepted data packet strobe |
| rx_done_len | output | LEN_W | Accepted packet length |
| rx_done_token | output | 8 | Token PID the data followed |
| rx_done_buf | output | 1 | Buffer index the packet was written to |
| rx_wr_sel | output | 1 | Buffer the receiver should fill next |

## Verification
On every cycle, assertions check the following. A short packet never yields a reply. An addressed SETUP/OUT token stays silent. A delivery always comes with an ACK. An accept never happens into an occupied buffer and always flips the buffer select. The transmit slot is only taken while it is loaded. What only the directed scenarios can show is the history-dependent behaviour: the token being cleared by each kind of dropped packet and kept across a NAK, the ordering of the data check ahead of the address check, the IN refusal while received data is unconsumed, and back-to-back token and data handling.

// File: rtl/usb_resp_pkg.sv
package usb_resp_pkg;
  localparam logic [7:0] PID_OUT   = 8'hE1;
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_DATA0 = 8'hC3;
  localparam logic [7:0] PID_DATA1 = 8'h4B;
  localparam logic [7:0] PID_ACK   = 8'hD2;
  localparam logic [7:0] PID_NAK   = 8'h5A;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_HS    = 2'd1,
    SRC_TXBUF = 2'd2
  } reply_src_e;

  typedef struct packed {
    logic long_enough;
    logic is_data;
    logic is_tok_in;
    logic is_tok_rx;
    logic addr_hit;
  } pkt_class_t;
endpackage

// File: rtl/usb_resp_pid_dec.sv
module usb_resp_pid_dec
  import usb_resp_pkg::*;
#(
  parameter int LEN_W   = 5,
  parameter int MIN_LEN = 3
) (
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [7:0]       pkt_pid,
  input  logic [7:0]       pkt_byte1,
  input  logic [6:0]       dev_addr,
  output pkt_class_t       cls
);
  localparam logic [LEN_W-1:0] MIN_LEN_V = LEN_W'(MIN_LEN);

  always_comb begin
    cls.long_enough = (pkt_len >= MIN_LEN_V);
    cls.is_data     = (pkt_pid == PID_DATA0) || (pkt_pid == PID_DATA1);
    cls.is_tok_in   = (pkt_pid == PID_IN);
    cls.is_tok_rx   = (pkt_pid == PID_SETUP) || (pkt_pid == PID_OUT);
    cls.addr_hit    = (pkt_byte1[6:0] == dev_addr);
  end
endmodule

// File: rtl/usb_resp_rxbuf.sv
module usb_resp_rxbuf (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic consumed,
  output logic busy,
  output logic sel
);
  logic busy_q, busy_d, sel_q, sel_d;

  always_comb begin
    busy_d = busy_q;
    if (accept)        busy_d = 1'b1;
    else if (consumed) busy_d = 1'b0;
    sel_d = accept ? ~sel_q : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (accept) sel_q <= sel_d;
    end
  end

  assign busy = busy_q;
  assign sel  = sel_q;

  // R6
  accept_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy_q);
  // R7
  sel_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (sel_q != $past(sel_q)));
endmodule

// File: rtl/usb_resp_txslot.sv
module usb_resp_txslot #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             take,
  output logic             pending,
  output logic [LEN_W-1:0] len
);
  logic             pend_q, pend_d;
  logic [LEN_W-1:0] len_q;

  always_comb begin
    pend_d = pend_q;
    if (load)      pend_d = 1'b1;
    else if (take) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      len_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (load) len_q <= load_len;
    end
  end

  assign pending = pend_q;
  assign len     = len_q;

  // R9
  take_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend_q);
  // R9
  take_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load) |=> !pend_q);
endmodule

// File: rtl/usb_resp_ctrl.sv
module usb_resp_ctrl
  import usb_resp_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  pkt_class_t       cls,
  input  logic [7:0]       pkt_pid,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             rx_busy,
  input  logic             rx_sel,
  input  logic             tx_pending,
  input  logic [LEN_W-1:0] tx_len,
  output logic             accept,
  output logic             take,
  output logic             reply_valid,
  output logic [1:0]       reply_src,
  output logic [7:0]       reply_pid,
  output logic [LEN_W-1:0] reply_len,
  output logic             rx_done_valid,
  output logic [LEN_W-1:0] rx_done_len,
  output logic [7:0]       rx_done_token,
  output logic             rx_done_buf
);
  localparam logic [LEN_W-1:0] HS_LEN = LEN_W'(1);

  logic [7:0] tok_q, tok_d;
  logic act_ign, act_nak, act_ack, act_send, act_store;

  logic             rv_q, rv_d;
  reply_src_e       rs_q, rs_d;
  logic [7:0]       rp_q, rp_d;
  logic [LEN_W-1:0] rl_q, rl_d;
  logic             dv_q;
  logic [LEN_W-1:0] dl_q;
  logic [7:0]       dt_q;
  logic             db_q;

  always_comb begin
    act_ign = 1'b0; act_nak = 1'b0; act_ack = 1'b0;
    act_send = 1'b0; act_store = 1'b0;
    if (pkt_valid) begin
      if (!cls.long_enough)   act_ign = 1'b1;
      else if (cls.is_data) begin
        if (tok_q == 8'h00)   act_ign = 1'b1;
        else if (rx_busy)     act_nak = 1'b1;
        else                  act_ack = 1'b1;
      end
      else if (!cls.addr_hit) act_ign = 1'b1;
      else if (cls.is_tok_in) begin
        if (!tx_pending || rx_busy) act_nak  = 1'b1;
        else                        act_send = 1'b1;
      end
      else if (cls.is_tok_rx) act_store = 1'b1;
      else                    act_ign   = 1'b1;
    end
  end

  always_comb begin
    tok_d = tok_q;
    if (act_store)    tok_d = pkt_pid;
    else if (act_ign) tok_d = 8'h00;
    rv_d = act_nak | act_ack | act_send;
    rs_d = act_send ? SRC_TXBUF : (act_nak | act_ack) ? SRC_HS : SRC_NONE;
    rp_d = act_ack ? PID_ACK : act_nak ? PID_NAK : 8'h00;
    rl_d = act_send ? tx_len : (act_nak | act_ack) ? HS_LEN : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q <= 8'h00;
      rv_q  <= 1'b0;
      rs_q  <= SRC_NONE;
      rp_q  <= 8'h00;
      rl_q  <= '0;
      dv_q  <= 1'b0;
      dl_q  <= '0;
      dt_q  <= 8'h00;
      db_q  <= 1'b0;
    end else begin
      if (pkt_valid) tok_q <= tok_d;
      rv_q <= rv_d;
      rs_q <= rs_d;
      rp_q <= rp_d;
      rl_q <= rl_d;
      dv_q <= act_ack;
      if (act_ack) begin
        dl_q <= pkt_len;
        dt_q <= tok_q;
        db_q <= rx_sel;
      end
    end
  end

  assign accept        = act_ack;
  assign take          = act_send;
  assign reply_valid   = rv_q;
  assign reply_src     = rs_q;
  assign reply_pid     = rp_q;
  assign reply_len     = rl_q;
  assign rx_done_valid = dv_q;
  assign rx_done_len   = dl_q;
  assign rx_done_token = dt_q;
  assign rx_done_buf   = db_q;

  // R1
  short_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !cls.long_enough) |=> (!reply_valid && !rx_done_valid));
  // R4
  token_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && cls.long_enough && cls.is_tok_rx && cls.addr_hit) |=> !reply_valid);
  // R7
  deliver_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_valid |-> (reply_valid && reply_pid == PID_ACK && reply_src == SRC_HS));
endmodule

// File: rtl/usb_txn_responder.sv
module usb_txn_responder
  import usb_resp_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int LEN_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [7:0]       pkt_pid,
  input  logic [7:0]       pkt_byte1,
  input  logic [6:0]       dev_addr,
  input  logic             tx_load,
  input  logic [LEN_W-1:0] tx_load_len,
  input  logic             rx_consumed,
  output logic             reply_valid,
  output logic [1:0]       reply_src,
  output logic [7:0]       reply_pid,
  output logic [LEN_W-1:0] reply_len,
  output logic             rx_done_valid,
  output logic [LEN_W-1:0] rx_done_len,
  output logic [7:0]       rx_done_token,
  output logic             rx_done_buf,
  output logic             rx_wr_sel
);
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  pkt_class_t       cls;
  logic             accept, take, rx_busy, tx_pending;
  logic [LEN_W-1:0] tx_len;

  usb_resp_pid_dec #(.LEN_W(LEN_W)) u_dec (
    .pkt_len(pkt_len), .pkt_pid(pkt_pid), .pkt_byte1(pkt_byte1),
    .dev_addr(dev_addr), .cls(cls)
  );

  usb_resp_rxbuf u_rxbuf (
    .clk(clk), .rst_n(srst_n), .accept(accept), .consumed(rx_consumed),
    .busy(rx_busy), .sel(rx_wr_sel)
  );

  usb_resp_txslot #(.LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst_n(srst_n), .load(tx_load), .load_len(tx_load_len),
    .take(take), .pending(tx_pending), .len(tx_len)
  );

  usb_resp_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(srst_n), .pkt_valid(pkt_valid), .cls(cls),
    .pkt_pid(pkt_pid), .pkt_len(pkt_len), .rx_busy(rx_busy),
    .rx_sel(rx_wr_sel), .tx_pending(tx_pending), .tx_len(tx_len),
    .accept(accept), .take(take), .reply_valid(reply_valid),
    .reply_src(reply_src), .reply_pid(reply_pid), .reply_len(reply_len),
    .rx_done_valid(rx_done_valid), .rx_done_len(rx_done_len),
    .rx_done_token(rx_done_token), .rx_done_buf(rx_done_buf)
  );
endmodule

// File: tb/tb_usb_txn_responder.sv
`timescale 1ns/1ps
module tb_usb_txn_responder;
  localparam int LEN_W = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic pkt_valid;
  logic [LEN_W-1:0] pkt_len;
  logic [7:0] pkt_pid, pkt_byte1;
  logic [6:0] dev_addr;
  logic tx_load;
  logic [LEN_W-1:0] tx_load_len;
  logic rx_consumed;
  logic reply_valid;
  logic [1:0] reply_src;
  logic [7:0] reply_pid;
  logic [LEN_W-1:0] reply_len;
  logic rx_done_valid;
  logic [LEN_W-1:0] rx_done_len;
  logic [7:0] rx_done_token;
  logic rx_done_buf;
  logic rx_wr_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  usb_txn_responder dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .pkt_pid(pkt_pid), .pkt_byte1(pkt_byte1), .dev_addr(dev_addr),
    .tx_load(tx_load), .tx_load_len(tx_load_len), .rx_consumed(rx_consumed),
    .reply_valid(reply_valid), .reply_src(reply_src), .reply_pid(reply_pid),
    .reply_len(reply_len), .rx_done_valid(rx_done_valid),
    .rx_done_len(rx_done_len), .rx_done_token(rx_done_token),
    .rx_done_buf(rx_done_buf), .rx_wr_sel(rx_wr_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive one packet for one cycle; returns at the negedge after it was sampled
  task automatic pkt(input logic [7:0] pid, input logic [7:0] b1, input int len);
    pkt_valid = 1'b1; pkt_pid = pid; pkt_byte1 = b1; pkt_len = LEN_W'(len);
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  task automatic expect_silent(input string req);
    chk({req, " reply_valid"}, reply_valid, 0);
    chk({req, " reply_src"}, reply_src, 0);
    chk({req, " rx_done_valid"}, rx_done_valid, 0);
  endtask

  task automatic expect_hs(input string req, input logic [7:0] pid);
    chk({req, " reply_valid"}, reply_valid, 1);
    chk({req, " reply_src"}, reply_src, 1);
    chk({req, " reply_pid"}, reply_pid, pid);
    chk({req, " reply_len"}, reply_len, 1);
  endtask

  task automatic consume();
    rx_consumed = 1'b1; @(negedge clk); rx_consumed = 1'b0;
  endtask

  task automatic load_tx(input int len);
    tx_load = 1'b1; tx_load_len = LEN_W'(len); @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic t_reset();
    // R12
    expect_silent("R12");
    chk("R12 rx_wr_sel", rx_wr_sel, 0);
    pkt(8'h69, 8'hA5, 3);       // IN: nothing loaded -> NAK shows tx slot empty
    expect_hs("R12", 8'h5A);
  endtask

  task automatic t_short();
    pkt(8'h2D, 8'hA5, 3);       // R4 pending token
    expect_silent("R4");
    pkt(8'hE1, 8'hA5, 2);       // R1 short
    expect_silent("R1");
    pkt(8'hC3, 8'h11, 6);       // R5 token cleared by short packet
    expect_silent("R5 short");
  endtask

  task automatic t_addr();
    pkt(8'hE1, 8'h26, 3);       // R3 mismatch
    expect_silent("R3");
    pkt(8'hC3, 8'h00, 5);
    expect_silent("R3 R5 data after mismatch");
  endtask

  task automatic t_accept();
    pkt(8'h2D, 8'hA5, 3);       // bit7 set, low bits match (R3)
    expect_silent("R4 setup");
    pkt(8'hC3, 8'h00, 10);      // R2 second byte mismatches, still accepted
    expect_hs("R7 R11 R2", 8'hD2);
    chk("R7 done_valid", rx_done_valid, 1);
    chk("R7 done_len", rx_done_len, 10);
    chk("R7 done_token", rx_done_token, 8'h2D);
    chk("R7 done_buf", rx_done_buf, 0);
    chk("R7 wr_sel", rx_wr_sel, 1);
    @(negedge clk);
    chk("R10 one-cycle reply", reply_valid, 0);
  endtask

  task automatic t_busy();
    pkt(8'hE1, 8'hA5, 3);
    expect_silent("R4 out");
    pkt(8'h4B, 8'h7F, 6);       // buffer still occupied
    expect_hs("R6", 8'h5A);
    chk("R6 no delivery", rx_done_valid, 0);
    chk("R6 sel kept", rx_wr_sel, 1);
    consume();
    pkt(8'h4B, 8'h7F, 6);       // token kept across NAK
    expect_hs("R6 R7", 8'hD2);
    chk("R7 done_len", rx_done_len, 6);
    chk("R6 token kept", rx_done_token, 8'hE1);
    chk("R7 done_buf", rx_done_buf, 1);
    chk("R7 wr_sel back", rx_wr_sel, 0);
  endtask

  task automatic t_in();
    load_tx(12);
    pkt(8'h69, 8'hA5, 3);       // rx still occupied
    expect_hs("R8 busy", 8'h5A);
    consume();
    pkt(8'h69, 8'hA5, 3);
    chk("R9 valid", reply_valid, 1);
    chk("R9 src", reply_src, 2);
    chk("R9 len", reply_len, 12);
    chk("R9 pid", reply_pid, 0);
    pkt(8'h69, 8'hA5, 3);       // slot was freed
    expect_hs("R9 R8 freed", 8'h5A);
    pkt(8'h69, 8'h24, 3);       // IN with wrong address
    expect_silent("R3 in");
  endtask

  task automatic t_unknown();
    pkt(8'hE1, 8'hA5, 3);
    expect_silent("R4");
    pkt(8'hA5, 8'hA5, 3);       // unknown PID
    expect_silent("R5 unknown");
    pkt(8'hC3, 8'h00, 4);
    expect_silent("R5 cleared");
  endtask

  task automatic t_b2b();
    pkt_valid = 1'b1; pkt_pid = 8'hE1; pkt_byte1 = 8'hA5; pkt_len = 5'd3;
    @(negedge clk);
    expect_silent("R10 token");
    pkt_pid = 8'hC3; pkt_byte1 = 8'h00; pkt_len = 5'd8;
    @(negedge clk);
    pkt_valid = 1'b0;
    expect_hs("R10 back-to-back", 8'hD2);
    chk("R10 done_len", rx_done_len, 8);
    chk("R10 done_token", rx_done_token, 8'hE1);
    @(negedge clk);
    chk("R10 drop", reply_valid, 0);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pkt_valid = 1'b0; pkt_len = '0; pkt_pid = '0; pkt_byte1 = '0;
    dev_addr = 7'h25; tx_load = 1'b0; tx_load_len = '0; rx_consumed = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_short();
    t_addr();
    t_accept();
    t_busy();
    t_in();
    t_unknown();
    t_b2b();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule